// File: doc/BRIEF.md
# Scanline Mirror Buffer

This block takes a stream of image pixels, one scanline after another, and sends each scanline back out with its pixel order reversed. Two single-line memories take turns: one records the incoming line while the other plays back the line received before it, last pixel first. The two memories trade roles whenever a new line begins. This keeps the output running at the input rate, with no idle cycles between lines, even when the lines arrive back to back.

Every accepted input pixel is paired with exactly one read from the other memory. The output therefore has the same pacing as the input: one output pixel follows each input pixel one clock later, and a gap in the input gives a gap at the same place in the output. The output is delayed by exactly one line, so the first line after reset or after the first line-start produces no output. Each input line is expected to carry exactly `LINE_LEN` pixels. If a line is cut short, the mirrored copy of it holds undefined stale pixels at its start.

Top module: `line_reverse_pp`

## Requirements
- R1: After reset `out_valid` is low. It stays low through the whole of the first line that follows the first line-start, and through a reset asserted in the middle of a stream.
- R2: Output line L is input line L-1 reversed: output pixel k of that line equals input pixel `LINE_LEN-1-k` of the previous line.
- R3: `out_sol` is high only on the first pixel of each reversed line. That pixel appears one clock after the input pixel that carries `in_sol` for the following line.
- R4: Every output pixel comes one clock after an accepted input pixel. An idle input cycle inside a line gives an idle output cycle one clock later.
- R5: Lines sent back to back, with no idle cycle between them, are mirrored with no lost or duplicated pixel at any line boundary.
- R6: Valid pixels that arrive before the first line-start since reset are discarded and produce no output.
- R7: Valid pixels beyond `LINE_LEN` within one line are discarded. They produce no output and do not change the stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sol | input | 1 | Input pixel is the first of a scanline (qualified by in_valid) |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sol | output | 1 | Output pixel is the first of a reversed scanline |
| out_pix | output | PIX_W | Output pixel value, zero when out_valid is low |

## Verification
The hardest case to reach is a bank swap on consecutive clocks. Here the last pixel of one line is written in the same cycle that the other memory finishes its playback, and on the very next clock that freshly written pixel must be the first one read. The stimulus sends several lines with no idle cycle between them, so every boundary lands on this case, and each pixel value is an arithmetic function of line and position. It also places surplus pixels after a full line and idle cycles inside a line. This shows that neither the pacing nor the stored copy of the line slips.

// File: rtl/lr_pkg.sv
package lr_pkg;

    // Tag carried alongside a memory read so the output stage can align
    // its flags with the registered memory data.
    typedef struct packed {
        logic valid;
        logic sol;
        logic bank;
    } rd_tag_t;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth <= 1) ? 1 : $clog2(depth);
    endfunction

    function automatic int unsigned count_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic logic [1:0] bank_onehot(input logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/lr_line_mem.sv
module lr_line_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 640,
    parameter int unsigned AW     = lr_pkg::addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/lr_seq.sv
module lr_seq
    import lr_pkg::*;
#(
    parameter int unsigned LINE_LEN = 640,
    parameter int unsigned AW       = addr_bits(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sol,
    output logic [1:0]    wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    rd_en,
    output logic [AW-1:0] rd_addr,
    output rd_tag_t       rd_tag
);

    localparam int unsigned CW = count_bits(LINE_LEN);
    localparam logic [CW-1:0] FULL = CW'(LINE_LEN);

    logic          wr_bank;
    logic          started;
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_left;

    logic new_line;
    logic bank_now;
    logic wr_ok;
    logic rd_ok;

    always_comb begin
        new_line = in_valid && in_sol;
        bank_now = new_line ? ~wr_bank : wr_bank;
        wr_ok    = new_line || (in_valid && started && (wr_cnt < FULL));
        rd_ok    = new_line ? started : (in_valid && (rd_left != '0));

        wr_addr  = new_line ? '0 : AW'(wr_cnt);
        rd_addr  = new_line ? AW'(LINE_LEN - 1) : AW'(rd_left - 1'b1);

        wr_en    = wr_ok ? bank_onehot(bank_now) : 2'b00;
        rd_en    = rd_ok ? bank_onehot(~bank_now) : 2'b00;

        rd_tag.valid = rd_ok;
        rd_tag.sol   = new_line && started;
        rd_tag.bank  = ~bank_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank <= 1'b0;
            started <= 1'b0;
            wr_cnt  <= FULL;
            rd_left <= '0;
        end else if (new_line) begin
            wr_bank <= ~wr_bank;
            started <= 1'b1;
            wr_cnt  <= CW'(1);
            rd_left <= started ? CW'(LINE_LEN - 1) : '0;
        end else if (in_valid) begin
            if (wr_ok) begin
                wr_cnt <= wr_cnt + 1'b1;
            end
            if (rd_left != '0) begin
                rd_left <= rd_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lr_out.sv
module lr_out
    import lr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  rd_tag_t                tag_in,
    input  logic [1:0][DATA_W-1:0] bank_q,
    output logic                   out_valid,
    output logic                   out_sol,
    output logic [DATA_W-1:0]      out_pix
);

    rd_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q <= tag_in;
        end
    end

    always_comb begin
        out_valid = tag_q.valid;
        out_sol   = tag_q.valid && tag_q.sol;
        out_pix   = tag_q.valid ? bank_q[tag_q.bank] : '0;
    end

endmodule

// File: rtl/line_reverse_pp.sv
module line_reverse_pp
    import lr_pkg::*;
#(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned LINE_LEN = 640
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sol,
    output logic [PIX_W-1:0] out_pix
);

    localparam int unsigned AW     = addr_bits(LINE_LEN);
    localparam int unsigned NBANKS = 2;

    logic [NBANKS-1:0]            wr_en;
    logic [NBANKS-1:0]            rd_en;
    logic [AW-1:0]                wr_addr;
    logic [AW-1:0]                rd_addr;
    rd_tag_t                      rd_tag;
    logic [NBANKS-1:0][PIX_W-1:0] bank_q;

    lr_seq #(
        .LINE_LEN (LINE_LEN),
        .AW       (AW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_tag   (rd_tag)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        lr_line_mem #(
            .DATA_W (PIX_W),
            .DEPTH  (LINE_LEN),
            .AW     (AW)
        ) u_mem (
            .clk    (clk),
            .we     (wr_en[b]),
            .waddr  (wr_addr),
            .wdata  (in_pix),
            .re     (rd_en[b]),
            .raddr  (rd_addr),
            .rdata  (bank_q[b])
        );
    end

    lr_out #(
        .DATA_W (PIX_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .tag_in    (rd_tag),
        .bank_q    (bank_q),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_pix   (out_pix)
    );

endmodule

// File: rtl/lr_checker.sv
module lr_checker #(
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned LINE_LEN = 640
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sol,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic             out_sol,
    input logic [PIX_W-1:0] out_pix
);

    logic [1:0] sol_seen;
    int unsigned out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sol_seen <= 2'd0;
            out_cnt  <= 0;
        end else begin
            if (in_valid && in_sol && sol_seen != 2'd2) begin
                sol_seen <= sol_seen + 2'd1;
            end
            if (out_valid) begin
                out_cnt <= out_sol ? 1 : out_cnt + 1;
            end
        end
    end

    // R1 / R6: nothing leaves before a second line-start was accepted
    p_no_early_output_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> sol_seen == 2'd2);

    // R4: every output pixel pairs with an input pixel one clock earlier
    p_paced_by_input_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R3: line start flag only on a valid pixel
    p_sol_qualified_r3: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

    // R3: reversed line begins one clock after the next input line-start
    p_sol_follows_input_r3: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> $past(in_valid && in_sol));

    // R7: never more than LINE_LEN pixels in one output line
    p_line_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sol) |-> out_cnt < LINE_LEN);

    // R4: invalid output carries a zero pixel
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_pix == '0);

endmodule

bind line_reverse_pp lr_checker #(
    .PIX_W    (PIX_W),
    .LINE_LEN (LINE_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_pix   (out_pix)
);

// File: tb/line_reverse_pp_tb.sv
`timescale 1ns/1ps
module line_reverse_pp_tb;

    localparam int N  = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic          out_valid;
    logic          out_sol;
    logic [PW-1:0] out_pix;

    int checks = 0;
    int fails  = 0;

    logic [PW-1:0] prev_line [N];
    logic [PW-1:0] cur_line  [N];
    bit            have_prev = 0;

    always #2 clk = ~clk;

    line_reverse_pp #(.PIX_W(PW), .LINE_LEN(N)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_pix   (out_pix)
    );

    function automatic logic [PW-1:0] pix_of(input int line, input int k);
        return PW'((line * 37 + k * 5 + 3) & 8'hFF);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle, then check the outputs produced by that edge
    task automatic cyc(input logic v, input logic s, input logic [PW-1:0] d,
                       input logic ev, input logic es, input logic [PW-1:0] ep,
                       input string req);
        in_valid = v;
        in_sol   = s;
        in_pix   = d;
        @(posedge clk);
        #1;
        check(req, "out_valid", int'(out_valid), int'(ev));
        if (ev) begin
            check("R3", "out_sol", int'(out_sol), int'(es));
            check(req, "out_pix", int'(out_pix), int'(ep));
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, req);
    endtask

    // send one full line; gap inserts an idle cycle after each pixel,
    // extra appends surplus pixels beyond the line length
    task automatic send_line(input int line, input bit gap, input int extra, input string req);
        for (int k = 0; k < N; k++) begin
            cur_line[k] = pix_of(line, k);
            if (have_prev)
                cyc(1'b1, k == 0, cur_line[k], 1'b1, k == 0, prev_line[N-1-k], req);
            else
                cyc(1'b1, k == 0, cur_line[k], 1'b0, 1'b0, '0, req);
            if (gap) cyc(1'b0, 1'b0, 8'hAA, 1'b0, 1'b0, '0, "R4");
        end
        for (int e = 0; e < extra; e++)
            cyc(1'b1, 1'b0, 8'h5A ^ PW'(e), 1'b0, 1'b0, '0, "R7");
        for (int k = 0; k < N; k++) prev_line[k] = cur_line[k];
        have_prev = 1;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        idle(2, "R1");

        // R6: pixels before any line-start are dropped
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, PW'(i + 200), 1'b0, 1'b0, '0, "R6");

        // R1: first line yields nothing
        send_line(0, 0, 0, "R1");
        // R2 / R5: back-to-back lines
        for (int l = 1; l <= 4; l++) send_line(l, 0, 0, (l == 1) ? "R2" : "R5");
        // R4: gapped line
        send_line(5, 1, 0, "R4");
        // R7: surplus pixels, then confirm stored line intact
        send_line(6, 0, 3, "R2");
        send_line(7, 0, 0, "R7");
        send_line(8, 0, 0, "R5");
        idle(3, "R4");

        // R1: reset mid-stream restarts the one-line delay
        rst = 1'b1;
        have_prev = 0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "out_valid during mid reset", int'(out_valid), 0);
        rst = 1'b0;
        send_line(9, 0, 0, "R1");
        send_line(10, 0, 0, "R2");
        send_line(11, 1, 0, "R4");
        idle(2, "R4");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule